// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the column engine of one bank of a synchronous DRAM. A small registered mode setting gives the burst length, the beat ordering and the read latency. Read, write and stop commands are sampled on each rising clock edge. A read or write command carries a starting column. From it the block produces one column per beat on consecutive cycles. It also raises a data strobe for each beat: in the beat's own cycle for writes, and a programmed number of cycles later for reads.

Beats follow one of two orders. Sequential order wraps inside the aligned block of the burst length. Interleaved order XORs the beat number into the low start bits. A sequential full-page mode keeps stepping around a 512-column page until it is stopped. A stop command ends issue at once, but reads already in the latency pipeline still deliver. A new read or write replaces the running burst on any cycle. A write also drops read data that has not yet appeared.

Top module: `sdram_burst_seq`

## Requirements
- R1: While `rst_n` is low, `beat_valid`, `beat_wr`, `dq_valid` and `dq_wr` are 0 and `beat_col` and `dq_col` are 0.
- R2: `cmd` encodes 0 = idle, 1 = read, 2 = write, 3 = stop. A read or write sampled at an edge shows beat 0, with `beat_col` equal to the sampled `cmd_col`, in the following cycle. Further beats follow on consecutive cycles. After the last beat `beat_valid` is 0.
- R3: In sequential order with burst length BL, beat k has column `(start & ~(BL-1)) | ((start + k) mod BL)`. The bits above the low log2(BL) bits never change during the burst.
- R4: In interleaved order, beat k has column `start` with its low log2(BL) bits XORed with k.
- R5: Sequential full page steps the column by one each cycle, wrapping from 511 to 0. It runs until a stop or a new read or write is sampled.
- R6: A full-page length code combined with interleaved order is treated as burst length 8.
- R7: `mode_we` loads `mode_bl`, `mode_ilv` (1 = interleaved) and `mode_cl3` (1 = latency 3, 0 = latency 2) at the edge. Length codes are 0→1, 1→2, 2→4, 3→8 and 7→full page, and the codes 4 to 6 give one beat. A burst keeps the length and order in force at the edge that sampled its command. A mode write at that same edge applies only to later commands.
- R8: After a stop sampled at an edge, `beat_valid` is 0 from the next cycle. Read beats already issued still produce their read strobes.
- R9: A read or write sampled while a burst runs abandons it. The new beat 0 appears in the next cycle.
- R10: During a write beat, `dq_valid` = 1, `dq_wr` = 1 and `dq_col` equals `beat_col` in the same cycle.
- R11: A read beat shown in cycle n gives `dq_valid` = 1, `dq_wr` = 0 and `dq_col` equal to that beat's column in cycle n+L. L is 3 when `mode_cl3` is 1 and 2 otherwise.
- R12: A write sampled at an edge discards every read beat issued before the write's first beat. Those beats never produce a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_we | input | 1 | Load the mode fields at this edge |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_cl3 | input | 1 | 1 = read latency 3, 0 = read latency 2 |
| cmd | input | 2 | 0 idle, 1 read, 2 write, 3 stop |
| cmd_col | input | COL_W | Starting column of a read or write |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_col | output | COL_W | Column of the current beat |
| beat_wr | output | 1 | Current beat belongs to a write |
| dq_valid | output | 1 | Data strobe |
| dq_col | output | COL_W | Column the strobe refers to |
| dq_wr | output | 1 | Strobe belongs to a write beat |

## Verification
The hardest case is the interaction of pre-emption with the read latency pipeline. The bench has to reach a stop landing while read beats are still in flight, a write arriving one cycle after a read, and a latency change while reads are pending. Each of these depends on the exact edge at which one command follows another. Directed sequences place such commands back to back. Long random runs then mix reads, writes, stops and mode loads at short intervals. A bench model keeps a per-cycle history of the expected beats. From it the model computes, in each cycle, which read beat is due at the current latency and whether a later write has discarded it.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_STOP  = 2'd3
    } cmd_e;

    localparam logic [2:0] BLC_1    = 3'd0;
    localparam logic [2:0] BLC_2    = 3'd1;
    localparam logic [2:0] BLC_4    = 3'd2;
    localparam logic [2:0] BLC_8    = 3'd3;
    localparam logic [2:0] BLC_PAGE = 3'd7;

    typedef struct packed {
        logic [2:0] bl;
        logic       ilv;
        logic       cl3;
    } mode_t;

    localparam int LAT_MAX = 3;

endpackage

// File: rtl/sbs_col_gen.sv
module sbs_col_gen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] hold_bits;
    logic [COL_W-1:0] seq_low;
    logic [COL_W-1:0] ilv_low;

    always_comb begin
        hold_bits = start & ~mask;
        seq_low   = (start + idx) & mask;
        ilv_low   = (start ^ idx) & mask;
        col       = hold_bits | (ilv ? ilv_low : seq_low);
    end

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
    parameter int COL_W = 9,
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             in_valid,
    input  logic [COL_W-1:0] in_col,
    input  logic             lat3,
    output logic             out_valid,
    output logic [COL_W-1:0] out_col
);

    typedef struct packed {
        logic             v;
        logic [COL_W-1:0] col;
    } stage_t;

    stage_t [DEPTH-1:0] stg_d;
    stage_t [DEPTH-1:0] stg_q;

    always_comb begin
        stg_d[0].v   = in_valid & ~flush;
        stg_d[0].col = flush ? '0 : in_col;
    end

    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_stage
        always_comb begin
            stg_d[gi] = flush ? '0 : stg_q[gi-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    stage_t tap;
    always_comb begin
        tap       = lat3 ? stg_q[DEPTH-1] : stg_q[DEPTH-2];
        out_valid = tap.v;
        out_col   = tap.v ? tap.col : '0;
    end

    AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid) else $error("flush left read data"); // R12

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sbs_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_we,
    input  logic [2:0]       mode_bl,
    input  logic             mode_ilv,
    input  logic             mode_cl3,
    input  logic [1:0]       cmd,
    input  logic [COL_W-1:0] cmd_col,
    output logic             beat_valid,
    output logic [COL_W-1:0] beat_col,
    output logic             beat_wr,
    output logic             dq_valid,
    output logic [COL_W-1:0] dq_col,
    output logic             dq_wr
);

    typedef struct packed {
        logic             valid;
        logic             wr;
        logic             fullpg;
        logic             ilv;
        logic [COL_W-1:0] mask;
        logic [COL_W-1:0] start;
        logic [COL_W-1:0] idx;
    } burst_t;

    cmd_e             cmd_v;
    mode_t            md_d, md_q;
    burst_t           st_d, st_q;
    logic [COL_W-1:0] col_d, col_q;
    logic [COL_W-1:0] new_mask;
    logic             new_fp;
    logic             rd_v;
    logic [COL_W-1:0] rd_col;

    assign cmd_v = cmd_e'(cmd);

    always_comb begin
        new_fp = 1'b0;
        unique case (md_q.bl)
            BLC_1:   new_mask = COL_W'(0);
            BLC_2:   new_mask = COL_W'(1);
            BLC_4:   new_mask = COL_W'(3);
            BLC_8:   new_mask = COL_W'(7);
            BLC_PAGE: begin
                if (md_q.ilv) begin
                    new_mask = COL_W'(7);
                end else begin
                    new_mask = '1;
                    new_fp   = 1'b1;
                end
            end
            default: new_mask = COL_W'(0);
        endcase
    end

    always_comb begin
        md_d = md_q;
        st_d = st_q;
        if (mode_we) begin
            md_d.bl  = mode_bl;
            md_d.ilv = mode_ilv;
            md_d.cl3 = mode_cl3;
        end
        unique case (cmd_v)
            CMD_READ, CMD_WRITE: begin
                st_d.valid  = 1'b1;
                st_d.wr     = (cmd_v == CMD_WRITE);
                st_d.fullpg = new_fp;
                st_d.ilv    = md_q.ilv;
                st_d.mask   = new_mask;
                st_d.start  = cmd_col;
                st_d.idx    = '0;
            end
            CMD_STOP: begin
                st_d.valid = 1'b0;
            end
            default: begin
                if (st_q.valid) begin
                    if (st_q.fullpg || (st_q.idx != st_q.mask)) begin
                        st_d.idx = st_q.idx + COL_W'(1);
                    end else begin
                        st_d.valid = 1'b0;
                    end
                end
            end
        endcase
    end

    sbs_col_gen #(.COL_W(COL_W)) u_col (
        .start (st_d.start),
        .idx   (st_d.idx),
        .mask  (st_d.mask),
        .ilv   (st_d.ilv),
        .col   (col_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_q  <= '0;
            st_q  <= '0;
            col_q <= '0;
        end else begin
            md_q  <= md_d;
            st_q  <= st_d;
            col_q <= col_d;
        end
    end

    sbs_rd_pipe #(.COL_W(COL_W), .DEPTH(LAT_MAX)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_v == CMD_WRITE),
        .in_valid  (st_q.valid & ~st_q.wr),
        .in_col    (col_q),
        .lat3      (md_q.cl3),
        .out_valid (rd_v),
        .out_col   (rd_col)
    );

    always_comb begin
        beat_valid = st_q.valid;
        beat_col   = st_q.valid ? col_q : '0;
        beat_wr    = st_q.valid & st_q.wr;
        dq_wr      = beat_wr;
        dq_valid   = beat_wr | rd_v;
        dq_col     = beat_wr ? col_q : rd_col;
    end

    AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1 || cmd == 2'd2) |=> beat_valid && beat_col == $past(cmd_col))
        else $error("new burst did not start at its column"); // R9

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'd3 |=> !beat_valid) else $error("beat after stop"); // R8

    AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && $past(beat_valid) && $past(cmd) == 2'd0)
        |-> ((beat_col ^ $past(beat_col)) & ~st_q.mask) == '0)
        else $error("upper column bits moved"); // R3

    AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        beat_wr |-> dq_valid && dq_wr && dq_col == beat_col)
        else $error("write strobe missing"); // R10

    AST_RD_LAT2: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_wr && !md_q.cl3)
        |-> $past(beat_valid, 2) && !$past(beat_wr, 2) && dq_col == $past(beat_col, 2))
        else $error("latency 2 read strobe wrong"); // R11

    AST_RD_LAT3: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_valid && !dq_wr && md_q.cl3)
        |-> $past(beat_valid, 3) && !$past(beat_wr, 3) && dq_col == $past(beat_col, 3))
        else $error("latency 3 read strobe wrong"); // R11

endmodule

// File: tb/tb_sdram_burst_seq.sv
module tb_sdram_burst_seq;

    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 9;
    localparam int HIST       = 4096;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_we = 1'b0;
    logic [2:0]       mode_bl = '0;
    logic             mode_ilv = 1'b0;
    logic             mode_cl3 = 1'b0;
    logic [1:0]       cmd = '0;
    logic [COL_W-1:0] cmd_col = '0;
    logic             beat_valid, beat_wr, dq_valid, dq_wr;
    logic [COL_W-1:0] beat_col, dq_col;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_seq #(.COL_W(COL_W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_bl(mode_bl),
        .mode_ilv(mode_ilv), .mode_cl3(mode_cl3), .cmd(cmd), .cmd_col(cmd_col),
        .beat_valid(beat_valid), .beat_col(beat_col), .beat_wr(beat_wr),
        .dq_valid(dq_valid), .dq_col(dq_col), .dq_wr(dq_wr)
    );

    int    nchk = 0;
    int    nerr = 0;
    string cur_req = "R1";
    bit    done = 0;

    int cyc = 0;
    bit bv[HIST];
    bit bw[HIST];
    int bc[HIST];
    int last_wr = -1000;

    bit m_act = 0, m_wr = 0, m_ilv = 0;
    int m_start = 0, m_k = 0, m_len = 1;
    int md_bl = 0;
    bit md_ilv = 0, md_cl3 = 0;

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_len(int code, bit ilv);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return ilv ? 8 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int col_of(int s, int k, int len, bit ilv);
        int base, off;
        if (len == 0) return (s + k) % 512;
        off  = s % len;
        base = s - off;
        if (ilv) return base + (off ^ k);
        return base + ((off + k) % len);
    endfunction

    task automatic step();
        int n, m, lat;
        bit ev, edv, edw;
        int edc;
        @(posedge clk);
        cyc++;
        if (cmd == 2'd1 || cmd == 2'd2) begin
            m_act = 1; m_wr = (cmd == 2'd2); m_start = int'(cmd_col);
            m_k = 0; m_len = eff_len(md_bl, md_ilv); m_ilv = md_ilv;
            if (cmd == 2'd2) last_wr = cyc;
        end else if (cmd == 2'd3) begin
            m_act = 0;
        end else if (m_act) begin
            m_k++;
            if (m_len != 0 && m_k >= m_len) m_act = 0;
        end
        if (mode_we) begin
            md_bl = int'(mode_bl); md_ilv = mode_ilv; md_cl3 = mode_cl3;
        end
        n = cyc % HIST;
        bv[n] = m_act;
        bw[n] = m_act && m_wr;
        bc[n] = m_act ? col_of(m_start, m_k, m_len, m_ilv) : 0;
        @(negedge clk);
        ev = bv[n];
        chk(cur_req, "beat_valid", int'(beat_valid), int'(ev));
        if (ev) begin
            chk(cur_req, "beat_col", int'(beat_col), bc[n]);
            chk(cur_req, "beat_wr", int'(beat_wr), int'(bw[n]));
        end
        edv = 0; edw = 0; edc = 0;
        if (bw[n]) begin
            edv = 1; edw = 1; edc = bc[n];
        end else begin
            lat = md_cl3 ? 3 : 2;
            m = cyc - lat;
            if (m > 0 && bv[m % HIST] && !bw[m % HIST] && last_wr <= m) begin
                edv = 1; edc = bc[m % HIST];
            end
        end
        chk(cur_req, "dq_valid", int'(dq_valid), int'(edv));
        if (edv) begin
            chk(cur_req, "dq_col", int'(dq_col), edc);
            chk(cur_req, "dq_wr", int'(dq_wr), int'(edw));
        end
        cmd = 2'd0;
        mode_we = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic issue(int c, int col);
        cmd = 2'(c);
        cmd_col = COL_W'(col);
        step();
    endtask

    task automatic load_mode(int bl, bit ilv, bit cl3);
        mode_we = 1'b1; mode_bl = 3'(bl); mode_ilv = ilv; mode_cl3 = cl3;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < HIST; i++) begin bv[i] = 0; bw[i] = 0; bc[i] = 0; end
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1", "beat_valid", int'(beat_valid), 0);
            chk("R1", "beat_wr", int'(beat_wr), 0);
            chk("R1", "dq_valid", int'(dq_valid), 0);
            chk("R1", "dq_wr", int'(dq_wr), 0);
            chk("R1", "beat_col", int'(beat_col), 0);
            chk("R1", "dq_col", int'(dq_col), 0);
        end
        rst_n = 1'b1;

        cur_req = "R3";
        load_mode(2, 0, 0);
        issue(1, 13);
        idle(6);
        load_mode(3, 0, 0);
        issue(1, 254);
        idle(10);

        cur_req = "R4";
        load_mode(3, 1, 0);
        issue(1, 13);
        idle(12);
        load_mode(2, 1, 1);
        issue(2, 6);
        idle(6);

        cur_req = "R6";
        load_mode(7, 1, 1);
        issue(2, 3);
        idle(10);

        cur_req = "R5";
        load_mode(7, 0, 0);
        issue(1, 508);
        idle(8);
        issue(3, 0);
        idle(5);

        cur_req = "R7";
        load_mode(5, 0, 0);
        issue(1, 100);
        idle(5);
        mode_we = 1'b1; mode_bl = 3'd3; mode_ilv = 1'b0; mode_cl3 = 1'b0;
        issue(1, 120);
        idle(4);
        issue(1, 120);
        idle(10);

        cur_req = "R8";
        load_mode(3, 0, 1);
        issue(1, 40);
        idle(2);
        issue(3, 0);
        idle(6);

        cur_req = "R9";
        load_mode(2, 0, 0);
        issue(1, 20);
        idle(1);
        issue(1, 33);
        idle(1);
        issue(2, 50);
        idle(6);

        cur_req = "R10";
        load_mode(3, 0, 0);
        issue(2, 7);
        idle(10);

        cur_req = "R11";
        load_mode(1, 0, 1);
        issue(1, 66);
        idle(6);
        load_mode(0, 0, 0);
        issue(1, 70);
        idle(5);

        cur_req = "R12";
        load_mode(2, 0, 1);
        issue(1, 80);
        issue(2, 90);
        idle(8);

        cur_req = "R2";
        load_mode(0, 0, 0);
        issue(2, 5);
        issue(1, 6);
        idle(5);
        load_mode(1, 0, 0);
        issue(1, 9);
        idle(4);

        cur_req = "random";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if ($urandom_range(0, 99) < 3) begin
                int codes[5] = '{0, 1, 2, 3, 7};
                mode_we = 1'b1;
                mode_bl = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 6))
                                                       : 3'(codes[$urandom_range(0, 4)]);
                mode_ilv = 1'($urandom_range(0, 1));
                mode_cl3 = 1'($urandom_range(0, 1));
            end
            cmd_col = COL_W'($urandom_range(0, 511));
            if (r < 12)      cmd = 2'd1;
            else if (r < 20) cmd = 2'd2;
            else if (r < 24) cmd = 2'd3;
            else             cmd = 2'd0;
            step();
        end
        idle(5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule